// File: doc/BRIEF.md
# MDIO Single-Command Management Controller

This block runs one Clause 22 management transaction for each command that software writes. Software sees three 32-bit words: a command word, a data word and a status word. A command carries the operation, the PHY address and the register number, and it sets a busy flag that the hardware clears by itself once the frame has finished on the wire. Write data is taken from the low half of the data word. Read data returns in the upper half of the same word. A status bit reports when the PHY did not answer a read.

On the line side the block produces the management clock from the system clock through a parameterised divider, and it drives a tri-state data line with separate output, output-enable and input pins. The line changes just after a falling clock edge and is sampled on a rising edge. For a read the controller releases the line from the turnaround onward. It checks that the PHY pulls the second turnaround bit low and shifts in the 16 data bits.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command, data and status words read as zero. `mdc_o` is low and `mdio_oe_o` is low.
- R2: A write to word 0 (`bus_addr_i` = 0) starts a transaction only when the block is idle, bit 20 is set, and exactly one of bit 17 (read) or bit 16 (write) is set. The PHY address comes from bits 12:8 and the register number from bits 4:0. Reading word 0 returns busy at bit 20, the stored read and write bits at 17 and 16, the PHY address at 12:8 and the register number at 4:0. Busy reads 1 until the transaction has completed and then clears without any software action.
- R3: A command written while busy is set is ignored. The stored command fields do not change, and no extra frame appears on the line.
- R4: `mdc_o` has a period of 2*HALF_DIV system clocks. `mdio_o` changes only together with a falling edge of `mdc_o`.
- R5: Each transaction puts 64 bits on the line, MSB first, in this order: 32 ones, start 01, opcode (10 for a read, 01 for a write), the 5-bit PHY address, the 5-bit register number, the turnaround, and 16 data bits.
- R6: For a read, `mdio_oe_o` is low from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround appear in bits 31:16 of word 1 once busy clears.
- R7: Bit 0 of word 2 is set when a completed read sampled a 1 in its second turnaround bit, and it is cleared by a completed read that sampled a 0 there.
- R8: Bits 15:0 of word 1 are writable, and a write transaction sends them as its data field with turnaround 10. Bits 31:16 of word 1 are not changed by bus writes.
- R9: A write to word 0 without bit 20 set, or with both or neither of bits 17 and 16 set, starts nothing.
- R10: While idle, `mdc_o` stays low and produces no edges. Each transaction produces exactly 64 rising edges of `mdc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Word select: 0 command, 1 data, 2 status |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for the selected word (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situations to reach from the ports are a command that arrives in the middle of a frame and a PHY that does not answer in the turnaround. The bench issues a second command on the very next bus cycle after a first one, while busy is set. It then checks that the stored command fields still match the first command and that exactly one frame reaches the PHY model. The PHY model in the bench drives a configurable turnaround value, so a failed answer is followed by a good one, and the status bit has to set and then clear again.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W      = 32;
  localparam int FRAME_LEN  = 64;
  localparam int TA_POS     = 46;   // first turnaround bit index
  localparam int DATA_POS   = 48;   // first data bit index
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int BUSY_BIT   = 20;
  localparam int RD_BIT     = 17;
  localparam int WR_BIT     = 16;

  localparam logic [1:0] WORD_CMD  = 2'd0;
  localparam logic [1:0] WORD_DATA = 2'd1;
  localparam logic [1:0] WORD_STAT = 2'd2;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == LAST);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  mdio_cmd_t       cmd_i,
  input  logic [15:0]     wdata_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            mdio_i,
  output logic            busy_o,
  output logic            mdio_o,
  output logic            mdio_oe_o,
  output logic            rd_done_o,
  output logic [15:0]     rd_data_o,
  output logic            rd_bad_o
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, last_q, is_rd_q, bad_q;
  logic [15:0]          in_q;
  logic [FRAME_LEN-1:0] frame;
  logic                 released;

  assign frame = {{32{1'b1}}, 2'b01, (cmd_i.rd ? 2'b10 : 2'b01),
                  cmd_i.phy, cmd_i.regad, 2'b10, wdata_i};

  assign released  = is_rd_q && (idx_q >= IDX_W'(TA_POS));
  assign busy_o    = busy_q;
  assign mdio_o    = sh_q[FRAME_LEN-1];
  assign mdio_oe_o = busy_q && !released;
  assign rd_done_o = busy_q && fall_i && last_q && is_rd_q;
  assign rd_data_o = in_q;
  assign rd_bad_o  = bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      is_rd_q <= 1'b0;
      bad_q   <= 1'b0;
      in_q    <= '0;
    end else if (start_i && !busy_q) begin
      sh_q    <= frame;
      idx_q   <= '0;
      busy_q  <= 1'b1;
      last_q  <= 1'b0;
      is_rd_q <= cmd_i.rd;
      bad_q   <= 1'b0;
    end else if (busy_q) begin
      if (rise_i) begin
        if (is_rd_q && idx_q == IDX_W'(TA_POS + 1)) bad_q <= mdio_i;
        if (is_rd_q && idx_q >= IDX_W'(DATA_POS)) in_q <= {in_q[14:0], mdio_i};
        if (idx_q == IDX_W'(FRAME_LEN - 1)) last_q <= 1'b1;
      end
      if (fall_i) begin
        if (last_q) begin
          busy_q <= 1'b0;
          last_q <= 1'b0;
        end else begin
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_reg_if.sv
module mdio_reg_if
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             busy_i,
  input  logic             rd_done_i,
  input  logic [15:0]      rd_data_i,
  input  logic             rd_bad_i,
  output logic             start_o,
  output mdio_cmd_t        cmd_o,
  output logic [15:0]      wdata_o
);
  mdio_cmd_t   cmd_q;
  logic [15:0] wr_half_q, rd_half_q;
  logic        bad_q;
  logic        op_ok;
  logic        unused_wbits;

  assign unused_wbits = ^{bus_wdata_i[31:21], bus_wdata_i[19:18], bus_wdata_i[15:13],
                          bus_wdata_i[7:5]};

  assign op_ok   = bus_wdata_i[BUSY_BIT] && (bus_wdata_i[RD_BIT] ^ bus_wdata_i[WR_BIT]);
  assign start_o = bus_we_i && (bus_addr_i == WORD_CMD) && op_ok && !busy_i;
  assign cmd_o   = cmd_q;
  assign wdata_o = wr_half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      wr_half_q <= '0;
      rd_half_q <= '0;
      bad_q     <= 1'b0;
    end else begin
      if (start_o) begin
        cmd_q.rd    <= bus_wdata_i[RD_BIT];
        cmd_q.wr    <= bus_wdata_i[WR_BIT];
        cmd_q.phy   <= bus_wdata_i[12:8];
        cmd_q.regad <= bus_wdata_i[4:0];
      end
      if (bus_we_i && bus_addr_i == WORD_DATA) wr_half_q <= bus_wdata_i[15:0];
      if (rd_done_i) begin
        rd_half_q <= rd_data_i;
        bad_q     <= rd_bad_i;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      WORD_CMD: begin
        bus_rdata_o[BUSY_BIT] = busy_i;
        bus_rdata_o[RD_BIT]   = cmd_q.rd;
        bus_rdata_o[WR_BIT]   = cmd_q.wr;
        bus_rdata_o[12:8]     = cmd_q.phy;
        bus_rdata_o[4:0]      = cmd_q.regad;
      end
      WORD_DATA: bus_rdata_o = {rd_half_q, wr_half_q};
      WORD_STAT: bus_rdata_o[0] = bad_q;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        busy, start, rise, fall, rd_done, rd_bad;
  logic [15:0] wdata, rd_data;
  mdio_cmd_t   cmd;

  // start is taken from the live bus word, cmd field copy lands the same edge
  mdio_cmd_t start_cmd;
  assign start_cmd = '{rd: bus_wdata_i[RD_BIT], wr: bus_wdata_i[WR_BIT],
                       phy: bus_wdata_i[12:8], regad: bus_wdata_i[4:0]};

  mdio_reg_if u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy),
    .rd_done_i   (rd_done),
    .rd_data_i   (rd_data),
    .rd_bad_i    (rd_bad),
    .start_o     (start),
    .cmd_o       (cmd),
    .wdata_o     (wdata)
  );

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (start_cmd),
    .wdata_i   (wdata),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_done_o (rd_done),
    .rd_data_o (rd_data),
    .rd_bad_o  (rd_bad)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk
  import mdio_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      busy,
  input logic      mdc_o,
  input logic      mdio_o,
  input logic      mdio_oe_o,
  input logic      bus_we_i,
  input logic [1:0] bus_addr_i,
  input mdio_cmd_t cmd
);
  // R10 / R1: idle line is quiet
  a_r10_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));

  // R3: stored command held when a command word arrives during busy
  a_r3_cmd_held_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bus_we_i && bus_addr_i == WORD_CMD) |=> $stable(cmd));

  // R4: data line only moves with a falling management clock
  a_r4_mdio_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc_o));

  // R6: once released inside a frame, the driver stays off
  a_r6_no_redrive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> !$rose(mdio_oe_o));

  // R2: busy clears together with a falling clock edge
  a_r2_busy_ends_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $fell(mdc_o));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy       (busy),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .cmd        (cmd)
);

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  wire         mdio_line;

  logic        phy_drv = 1'b0, phy_val = 1'b0;
  logic        phy_ta = 1'b0;
  logic [15:0] phy_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_cmd_ctrl #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_line)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- PHY model and monitor ----------------
  logic [63:0] exp_q[$];
  logic [63:0] line_sh = '0;
  logic [5:0]  bit_cnt = '0;
  logic        phy_is_rd = 1'b0;
  int          frames = 0, rises = 0;
  time         last_rise = 0, period = 0;

  always @(posedge mdc) begin
    period    = $time - last_rise;
    last_rise = $time;
    rises++;
    if (phy_is_rd && bit_cnt == 6'd47)
      chk("R6 oe released in turnaround", {63'd0, mdio_oe}, 64'd0);
    line_sh = {line_sh[62:0], mdio_line};
    bit_cnt = bit_cnt + 1'b1;
    if (bit_cnt == 6'd36) phy_is_rd = (line_sh[1:0] == 2'b10);
    if (bit_cnt == 6'd0) begin
      frames++;
      phy_is_rd = 1'b0;
      if (exp_q.size() == 0) chk("R3 unexpected frame", line_sh, 64'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R5 frame on line", line_sh, e);
      end
    end
  end

  always @(negedge mdc) begin
    if (phy_is_rd && bit_cnt == 6'd47) begin
      phy_drv = 1'b1; phy_val = phy_ta;
    end else if (phy_is_rd && bit_cnt >= 6'd48) begin
      phy_drv = 1'b1; phy_val = phy_rdata[63 - int'(bit_cnt)];
    end else begin
      phy_drv = 1'b0;
    end
  end

  // ---------------- bus driver ----------------
  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(2'd0, v);
      if (!v[20]) return;
    end
    chk("R2 busy never cleared", 64'd1, 64'd0);
  endtask

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] rd_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic ta, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 1'b1, ta, d};
  endfunction

  task automatic issue_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    exp_q.push_back(wr_frame(p, r, d));
    bus_wr(2'd0, 32'h0011_0000 | {19'd0, p, 3'd0, r});
  endtask

  task automatic issue_read(input logic [4:0] p, input logic [4:0] r, input logic ta,
                            input logic [15:0] d);
    phy_ta = ta; phy_rdata = d;
    exp_q.push_back(rd_frame(p, r, ta, d));
    bus_wr(2'd0, 32'h0012_0000 | {19'd0, p, 3'd0, r});
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int f0, r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mdc low", {63'd0, mdc}, 64'd0);
    chk("R1 oe low", {63'd0, mdio_oe}, 64'd0);
    rst_ni = 1'b1;
    bus_rd(2'd0, v); chk("R1 command word", {32'd0, v}, 64'd0);
    bus_rd(2'd1, v); chk("R1 data word", {32'd0, v}, 64'd0);
    bus_rd(2'd2, v); chk("R1 status word", {32'd0, v}, 64'd0);

    // R8: data low half writable, upper half not
    bus_wr(2'd1, 32'hFFFF_A5C3);
    bus_rd(2'd1, v); chk("R8 data write low half only", {32'd0, v}, {32'd0, 32'h0000_A5C3});

    // R2/R5/R8: write transaction
    issue_write(5'd5, 5'h1B, 16'hA5C3);
    bus_rd(2'd0, v); chk("R2 busy set with fields", {32'd0, v}, {32'd0, 32'h0011_051B});
    wait_idle();
    bus_rd(2'd0, v); chk("R2 busy self-clears", {32'd0, v}, {32'd0, 32'h0001_051B});
    chk("R4 mdc period", 64'(period), 64'(2 * HALF_DIV * CLK_PERIOD));
    chk("R10 rises per frame", 64'(rises), 64'd64);

    // R6/R7: good read
    issue_read(5'h12, 5'h02, 1'b0, 16'h1234);
    wait_idle();
    bus_rd(2'd1, v); chk("R6 read data in upper half", {32'd0, v}, {32'd0, 32'h1234_A5C3});
    bus_rd(2'd2, v); chk("R7 status valid", {32'd0, v}, 64'd0);

    // R7: PHY silent in turnaround
    issue_read(5'h1F, 5'h10, 1'b1, 16'hBEEF);
    wait_idle();
    bus_rd(2'd2, v); chk("R7 status invalid set", {32'd0, v}, 64'd1);
    bus_rd(2'd1, v); chk("R6 sampled bits stored", {32'd0, v}, {32'd0, 32'hBEEF_A5C3});

    // R7: cleared by the next good read
    issue_read(5'h01, 5'h1E, 1'b0, 16'h0F0F);
    wait_idle();
    bus_rd(2'd2, v); chk("R7 status cleared", {32'd0, v}, 64'd0);
    bus_rd(2'd1, v); chk("R6 second read data", {32'd0, v}, {32'd0, 32'h0F0F_A5C3});

    // R3: command during busy ignored
    bus_wr(2'd1, 32'h0000_5A5A);
    f0 = frames;
    issue_write(5'd3, 5'd4, 16'h5A5A);
    bus_wr(2'd0, 32'h0012_0907);
    bus_rd(2'd0, v); chk("R3 fields held while busy", {32'd0, v}, {32'd0, 32'h0011_0304});
    wait_idle();
    repeat (200) @(negedge clk);
    chk("R3 exactly one frame", 64'(frames - f0), 64'd1);
    chk("R3 nothing pending", 64'(exp_q.size()), 64'd0);

    // R9: malformed commands start nothing
    r0 = rises;
    bus_wr(2'd0, 32'h0013_0105);
    bus_rd(2'd0, v); chk("R9 both ops no busy", {63'd0, v[20]}, 64'd0);
    bus_wr(2'd0, 32'h0002_0105);
    bus_rd(2'd0, v); chk("R9 no busy bit no start", {63'd0, v[20]}, 64'd0);
    bus_wr(2'd0, 32'h0010_0105);
    bus_rd(2'd0, v); chk("R9 no op bits no start", {63'd0, v[20]}, 64'd0);
    repeat (100) @(negedge clk);
    chk("R10 no mdc edges when idle", 64'(rises - r0), 64'd0);
    chk("R10 total rises", 64'(rises), 64'(64 * frames));
    bus_rd(2'd0, v); chk("R9 fields unchanged", {32'd0, v}, {32'd0, 32'h0001_0304});

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule